// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a pipelined SIMD datapath for integer dot products on a 512-bit vector. The vector is split into sixteen independent 32-bit lanes. Each lane takes a 32-bit slice of two source vectors and a 32-bit accumulator element. It multiplies the narrow elements pairwise, adds the products together, and adds that total to the accumulator. The lane sum is not split into separate multiply-add steps at 16 or 32 bits; it is formed in one step. No intermediate width can saturate or truncate.

There are two element modes. In byte mode each lane forms four products. The first source bytes are unsigned and the second source bytes are signed. In halfword mode each lane forms two signed-by-signed products.

The pipeline has three stages: multiply, adder tree, accumulate. It accepts a new operation on every clock. A valid bit travels with each operation. The result register keeps its last value during cycles with no result.

Top module: `dotp_accum`

## Requirements
- R1: With `mode` = 0 (byte mode), result lane k = acc lane k + Σ_{j=0..3} U(src_a byte 4k+j) × S(src_b byte 4k+j). U is unsigned 8-bit, S is signed 8-bit, and byte i occupies bits [8i+7:8i].
- R2: With `mode` = 1 (halfword mode), result lane k = acc lane k + Σ_{j=0..1} S(src_a half 2k+j) × S(src_b half 2k+j). Both sources are signed 16-bit, and half i occupies bits [16i+15:16i].
- R3: Products and the lane sum are exact, with no saturation. For example, in halfword mode two products of -32768 × -32768 sum to 2^31. In byte mode four products of 255 × -128 sum to -130560.
- R4: The final addition to the accumulator wraps modulo 2^32. For example, 0x7FFFFFFF + 3 gives 0x80000002.
- R5: Result lane k depends only on bits [32k+31:32k] of `src_a`, `src_b` and `acc_in`.
- R6: Each operation takes three clock cycles. An operation captured with `in_valid` at clock edge N appears with `out_valid` high after edge N+2. `out_valid` is never high without such an operation. Operations on back-to-back edges give results on back-to-back cycles.
- R7: A synchronous active-high `rst` clears every pipeline valid bit and the result register. Work in flight when reset is applied never appears at the output.
- R8: While `out_valid` is low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle form an operation |
| mode | input | 1 | 0 = byte mode, 1 = halfword mode |
| src_a | input | 512 | First source vector (unsigned bytes, or signed halves) |
| src_b | input | 512 | Second source vector (signed bytes or halves) |
| acc_in | input | 512 | Sixteen 32-bit accumulator elements |
| out_valid | output | 1 | `result` holds a new operation's result |
| result | output | 512 | Sixteen 32-bit accumulated elements |

## Verification
Saturating extremes are applied in both modes. All-0xFF bytes times all-0x80 bytes and all-0x8000 halves squared separate an exact lane sum from a 16-bit-saturating chain and from the wrong signedness. An accumulator near 0x7FFFFFFF shows whether the final add wraps. A vector with a single nonzero lane and distinct accumulators per lane exposes leakage between lanes. Random operands with random mode switches, issued back to back and with random gaps, are compared every cycle against a queue-based model to check latency, hold behaviour and a reset that flushes work in flight.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

    localparam int LANE_W = 32;
    localparam int SUBS   = 4;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int PROD_W = 33;
    localparam int SUM_W  = 35;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_HALF = 1'b1
    } dot_mode_e;

    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic [LANE_W-1:0]   acc;
        prod_t [SUBS-1:0]    p;
    } lane_s1_t;

    typedef struct packed {
        logic [LANE_W-1:0] acc;
        sum_t              sum;
    } lane_s2_t;

    // unsigned byte times signed byte, exact
    function automatic prod_t mul_u8_s8(input logic [BYTE_W-1:0] u, input logic [BYTE_W-1:0] s);
        prod_t r;
        r = $signed({1'b0, u}) * $signed(s);
        return r;
    endfunction

    // signed half times signed half, exact
    function automatic prod_t mul_s16_s16(input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] y);
        prod_t r;
        r = $signed(x) * $signed(y);
        return r;
    endfunction

    function automatic sum_t add_products(input prod_t [SUBS-1:0] p);
        sum_t r;
        r = '0;
        for (int i = 0; i < SUBS; i++) begin
            r = r + sum_t'(p[i]);
        end
        return r;
    endfunction

endpackage

// File: rtl/dotp_mul_stage.sv
module dotp_mul_stage
    import dotp_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  dot_mode_e              mode,
    input  logic [VEC_W-1:0]       src_a,
    input  logic [VEC_W-1:0]       src_b,
    input  logic [VEC_W-1:0]       acc_in,
    output logic                   s1_valid,
    output dot_mode_e              s1_mode,
    output lane_s1_t [LANES-1:0]   s1_lane
);

    lane_s1_t [LANES-1:0] lane_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] a_w, b_w;
        assign a_w = src_a[l*LANE_W +: LANE_W];
        assign b_w = src_b[l*LANE_W +: LANE_W];

        always_comb begin
            lane_nxt[l].acc = acc_in[l*LANE_W +: LANE_W];
            if (mode == MODE_BYTE) begin
                for (int j = 0; j < SUBS; j++) begin
                    lane_nxt[l].p[j] = mul_u8_s8(a_w[j*BYTE_W +: BYTE_W], b_w[j*BYTE_W +: BYTE_W]);
                end
            end else begin
                for (int j = 0; j < SUBS; j++) begin
                    if (j < LANE_W / HALF_W) begin
                        lane_nxt[l].p[j] = mul_s16_s16(a_w[j*HALF_W +: HALF_W], b_w[j*HALF_W +: HALF_W]);
                    end else begin
                        lane_nxt[l].p[j] = '0;
                    end
                end
            end
        end

        for (genvar j = 0; j < SUBS; j++) begin : g_sub
            // R1
            byte_prod_range_chk: assert property (@(posedge clk) disable iff (rst)
                (s1_valid && s1_mode == MODE_BYTE) |->
                ($signed(s1_lane[l].p[j]) <= 33'sd32385 && $signed(s1_lane[l].p[j]) >= -33'sd32640));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_mode <= mode;
            s1_lane <= lane_nxt;
        end
    end

endmodule

// File: rtl/dotp_tree_stage.sv
module dotp_tree_stage
    import dotp_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s1_valid,
    input  dot_mode_e              s1_mode,
    input  lane_s1_t [LANES-1:0]   s1_lane,
    output logic                   s2_valid,
    output dot_mode_e              s2_mode,
    output lane_s2_t [LANES-1:0]   s2_lane
);

    lane_s2_t [LANES-1:0] lane_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            lane_nxt[l].acc = s1_lane[l].acc;
            lane_nxt[l].sum = add_products(s1_lane[l].p);
        end

        // R3
        sum_range_chk: assert property (@(posedge clk) disable iff (rst)
            (s2_valid && s2_mode == MODE_HALF) |->
            ($signed(s2_lane[l].sum) <= 35'sd2147483648 && $signed(s2_lane[l].sum) >= -35'sd2147483648));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            s2_mode <= s1_mode;
            s2_lane <= lane_nxt;
        end
    end

endmodule

// File: rtl/dotp_acc_stage.sv
module dotp_acc_stage
    import dotp_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s2_valid,
    input  lane_s2_t [LANES-1:0]   s2_lane,
    output logic                   out_valid,
    output logic [VEC_W-1:0]       result
);

    logic [VEC_W-1:0] result_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            result_nxt[l*LANE_W +: LANE_W] = s2_lane[l].acc + s2_lane[l].sum[LANE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                result <= result_nxt;
            end
        end
    end

    // R7
    reset_flush_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(result));

endmodule

// File: rtl/dotp_accum.sv
module dotp_accum
    import dotp_pkg::*;
#(
    parameter int VEC_W = 512,
    localparam int LANES = VEC_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  acc_in,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);

    logic                  s1_valid, s2_valid;
    dot_mode_e             s1_mode, s2_mode;
    lane_s1_t [LANES-1:0]  s1_lane;
    lane_s2_t [LANES-1:0]  s2_lane;
    dot_mode_e             mode_e;

    assign mode_e = dot_mode_e'(mode);

    dotp_mul_stage #(.LANES(LANES)) mul_u (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mode     (mode_e),
        .src_a    (src_a),
        .src_b    (src_b),
        .acc_in   (acc_in),
        .s1_valid (s1_valid),
        .s1_mode  (s1_mode),
        .s1_lane  (s1_lane)
    );

    dotp_tree_stage #(.LANES(LANES)) tree_u (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_mode  (s1_mode),
        .s1_lane  (s1_lane),
        .s2_valid (s2_valid),
        .s2_mode  (s2_mode),
        .s2_lane  (s2_lane)
    );

    dotp_acc_stage #(.LANES(LANES)) acc_u (
        .clk       (clk),
        .rst       (rst),
        .s2_valid  (s2_valid),
        .s2_lane   (s2_lane),
        .out_valid (out_valid),
        .result    (result)
    );

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

endmodule

// File: tb/dotp_accum_tb_top.sv
module dotp_accum_tb_top;

    localparam int W = 512;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] src_a = '0, src_b = '0, acc_in = '0;
    logic         out_valid;
    logic [W-1:0] result;
    string        cur_tag = "R1";

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    logic [W-1:0] hold_ref = '0;

    typedef struct {
        int           due;
        logic [W-1:0] data;
        string        tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    dotp_accum dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] ref_calc(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [W-1:0] c, input logic m);
        logic [W-1:0] r;
        for (int k = 0; k < W/32; k++) begin
            longint s;
            s = longint'($signed(c[32*k +: 32]));
            if (!m) begin
                for (int j = 0; j < 4; j++)
                    s += longint'(a[32*k+8*j +: 8]) * longint'($signed(b[32*k+8*j +: 8]));
            end else begin
                for (int j = 0; j < 2; j++)
                    s += longint'($signed(a[32*k+16*j +: 16])) * longint'($signed(b[32*k+16*j +: 16]));
            end
            r[32*k +: 32] = s[31:0];
        end
        return r;
    endfunction

    // reference model: queue of expected results, each with the cycle it is due
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            hold_ref = '0;
        end else if (in_valid) begin
            q.push_back('{cyc + 3, ref_calc(src_a, src_b, acc_in, mode), cur_tag});
        end
        cyc = cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            nvec++;
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                if (!out_valid) begin
                    nfail++;
                    $display("FAIL R6 cycle %0d: out_valid=%0b expected 1", cyc, out_valid);
                end else if (result !== e.data) begin
                    nfail++;
                    $display("FAIL %s cycle %0d: result=%h expected %h", e.tag, cyc, result, e.data);
                end
                hold_ref = e.data;
            end else begin
                if (out_valid !== 1'b0) begin
                    nfail++;
                    $display("FAIL R6 cycle %0d: out_valid=%0b expected 0", cyc, out_valid);
                end else if (result !== hold_ref) begin
                    nfail++;
                    $display("FAIL R8 cycle %0d: result=%h expected %h", cyc, result, hold_ref);
                end
            end
        end
    end

    task automatic op(input logic m, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        src_a    = a;
        src_b    = b;
        acc_in   = c;
        cur_tag  = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a    = {16{32'hDEADBEEF}};
            src_b    = {16{32'h5A5A5A5A}};
        end
    endtask

    task automatic check_reset_state(input string where);
        nvec++;
        if (out_valid !== 1'b0 || result !== '0) begin
            nfail++;
            $display("FAIL R7 %s: out_valid=%0b result=%h expected 0 and 0", where, out_valid, result);
        end
    endtask

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R6 watchdog expired: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] va, vb, vc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("after power-up reset");

        // R3: byte extremes, 255 * -128 four times
        op(1'b0, {64{8'hFF}}, {64{8'h80}}, '0, "R3");
        // R3 R4: halfword -32768 squared twice gives 2^31
        op(1'b1, {32{16'h8000}}, {32{16'h8000}}, '0, "R4");
        // R4: accumulator wrap
        op(1'b0, {64{8'h01}}, {64{8'h01}}, {16{32'h7FFFFFFF}}, "R4");
        // R1: unsigned first source, signed second source
        op(1'b0, {16{32'h80_7F_02_FF}}, {16{32'hFF_FF_FE_7F}}, {16{32'h00000010}}, "R1");
        // R2: mixed-sign halves
        op(1'b1, {16{32'h7FFF_8001}}, {16{32'h8000_7FFF}}, {16{32'hFFFFFFF0}}, "R2");
        idle(3);

        // R5: only lane 5 active, distinct accumulators per lane
        va = '0; vb = '0;
        va[5*32 +: 32] = 32'h0A0B0C0D;
        vb[5*32 +: 32] = 32'hF1F2F3F4;
        for (int k = 0; k < W/32; k++) vc[32*k +: 32] = 32'h1000 * k + k;
        op(1'b0, va, vb, vc, "R5");
        op(1'b1, va, vb, vc, "R5");
        idle(2);

        // R8: long gap with changing inputs, result must hold
        idle(6);

        // R6: back-to-back random with mode switches
        for (int i = 0; i < 40; i++)
            op(i[0], rnd_vec(), rnd_vec(), rnd_vec(), i[0] ? "R2" : "R1");
        idle(4);

        // R7: reset with work in flight
        op(1'b0, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
        op(1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("after mid-run reset");
        idle(4);

        // random traffic with gaps
        for (int i = 0; i < 400; i++) begin
            logic m;
            m = $urandom_range(0, 1);
            if ($urandom_range(0, 9) < 7) op(m, rnd_vec(), rnd_vec(), rnd_vec(), m ? "R2" : "R1");
            else idle(1);
        end
        idle(6);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule